// File: doc/BRIEF.md
# Cassette Tone-Cycle Bit Demodulator

This block turns the squared-up output of a zero-crossing comparator on a cassette input into a byte stream. It does not sample at a fixed baud rate. It times each complete tone cycle, measured from one qualified rising crossing to the next. A long cycle, near the 1200 Hz tone, is a 0 bit. A short cycle, near the 2400 Hz tone, is a 1 bit. A cycle that is much too long or much too short is reported as an error, and the byte alignment is dropped.

Decoded bits enter a shift register least significant bit first. In hunt mode the register is compared with a programmable sync byte after every bit. Once the sync byte is found, a byte strobe is issued every eighth bit after it. In raw mode bytes are framed from the first decoded bit after reset or after an error. A running modulo-256 sum of the emitted bytes lets the host check the block checksum.

All timing is given in clock cycles. `P0_CYC` and `P1_CYC` are the nominal 0 and 1 periods, and `MIN_HIGH` is the deglitch length.

Top module: `cas_demod`

## Requirements
- R1: After a synchronous reset, `byte_stb`, `sync_found`, `bit_err` and `aligned` are 0 and `chk_sum` is 0x00.
- R2: A cycle whose period in clock cycles is at least the threshold (P0_CYC+P1_CYC)/2 decodes as 0. A shorter valid period decodes as 1. With the defaults (64 and 32), a period of 48 gives 0 and 47 gives 1.
- R3: A period greater than 3*P0_CYC/2 (96 by default) or less than P1_CYC/2 (16 by default) produces a one-cycle `bit_err` pulse and no bit. The limits 96 and 16 are themselves valid.
- R4: The input passes through a two-flop synchroniser. A high phase shorter than MIN_HIGH clock cycles is not a crossing and does not affect decoding.
- R5: With `sync_en`=1 and no lock, the shift register is compared with `sync_byte` after each bit. A match gives a one-cycle `sync_found` pulse and sets `aligned`. No byte is strobed before the match.
- R6: Once aligned, every eighth bit gives a one-cycle `byte_stb`. `byte_data` holds the byte, and its bit 0 is the earliest bit received.
- R7: A `bit_err` clears `aligned` and the bit count. Bytes resume only after the sync byte is found again.
- R8: With `sync_en`=0, bytes are framed every eight bits, starting with the first decoded bit after reset or after an error. In this mode `aligned` stays 0.
- R9: `chk_sum` is the modulo-256 sum of all bytes strobed since the last reset or sync match. It is updated in the same cycle as `byte_stb`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cas_in | input | 1 | Zero-crossing comparator output, asynchronous |
| sync_en | input | 1 | 1: hunt for the sync byte; 0: raw framing |
| sync_byte | input | 8 | Sync pattern to hunt for |
| byte_data | output | 8 | Last assembled byte |
| byte_stb | output | 1 | One-cycle strobe, byte_data valid |
| sync_found | output | 1 | One-cycle pulse on a sync match |
| bit_err | output | 1 | One-cycle pulse on an out-of-range period |
| aligned | output | 1 | Lock on the sync byte |
| chk_sum | output | 8 | Running modulo-256 byte sum |

## Verification
The in-line assertions check, on every cycle, the rules that tie signals together in time. A qualified edge never repeats on consecutive cycles. A period event is never both a bit and an error. Every byte strobe follows a decoded bit and moves the sum by exactly that byte. An error always drops the lock, and a sync match always raises it. Only the directed scenarios can show the values: the boundary periods at the threshold and both error limits, glitch rejection, LSB-first byte contents, re-hunting after an error, raw framing, and the checksum total.

// File: rtl/cas_demod_pkg.sv
package cas_demod_pkg;

    typedef enum logic [1:0] {
        CLS_ZERO = 2'd0,
        CLS_ONE  = 2'd1,
        CLS_ERR  = 2'd2
    } cycle_cls_e;

    typedef struct packed {
        logic vld;
        logic val;
        logic err;
    } bit_evt_t;

    function automatic cycle_cls_e classify_period(
        input int unsigned per,
        input int unsigned thr,
        input int unsigned lo_lim,
        input int unsigned hi_lim
    );
        if (per < lo_lim || per > hi_lim)
            return CLS_ERR;
        else if (per >= thr)
            return CLS_ZERO;
        else
            return CLS_ONE;
    endfunction

endpackage

// File: rtl/cas_edge_filter.sv
module cas_edge_filter #(
    parameter int MIN_HIGH = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise_ok
);
    localparam int HW = $clog2(MIN_HIGH + 1);

    logic          s1, s2;
    logic [HW-1:0] hi_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1      <= 1'b0;
            s2      <= 1'b0;
            hi_cnt  <= '0;
            rise_ok <= 1'b0;
        end else begin
            s1 <= din;
            s2 <= s1;
            if (!s2)
                hi_cnt <= '0;
            else if (hi_cnt != HW'(MIN_HIGH))
                hi_cnt <= hi_cnt + 1'b1;
            rise_ok <= s2 && (hi_cnt == HW'(MIN_HIGH - 1));
        end
    end

    AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        rise_ok |=> !rise_ok); // R4

endmodule

// File: rtl/cas_period_meter.sv
module cas_period_meter
    import cas_demod_pkg::*;
#(
    parameter int P0_CYC = 64,
    parameter int P1_CYC = 32
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     rise_ok,
    output bit_evt_t evt
);
    localparam int THR    = (P0_CYC + P1_CYC) / 2;
    localparam int LO_LIM = P1_CYC / 2;
    localparam int HI_LIM = (3 * P0_CYC) / 2;
    localparam int SAT    = HI_LIM + 1;
    localparam int CW     = $clog2(SAT + 1);

    logic [CW-1:0] cnt;
    logic          armed;
    cycle_cls_e    cls;

    always_comb cls = classify_period(int'(cnt) + 1, THR, LO_LIM, HI_LIM);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            armed <= 1'b0;
            evt   <= '0;
        end else begin
            evt <= '0;
            if (rise_ok) begin
                cnt   <= '0;
                armed <= 1'b1;
                if (armed) begin
                    evt.vld <= (cls != CLS_ERR);
                    evt.val <= (cls == CLS_ONE);
                    evt.err <= (cls == CLS_ERR);
                end
            end else if (cnt != CW'(SAT)) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    AST_BIT_OR_ERR: assert property (@(posedge clk) disable iff (rst)
        !(evt.vld && evt.err)); // R3

endmodule

// File: rtl/cas_byte_framer.sv
module cas_byte_framer
    import cas_demod_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  bit_evt_t   evt,
    input  logic       sync_en,
    input  logic [7:0] sync_byte,
    output logic [7:0] byte_data,
    output logic       byte_stb,
    output logic       sync_found,
    output logic       aligned,
    output logic [7:0] chk_sum
);
    logic [7:0] sr, sr_n;
    logic [2:0] bcnt;
    logic       framing;

    always_comb begin
        sr_n    = {evt.val, sr[7:1]};
        framing = aligned || !sync_en;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sr         <= '0;
            bcnt       <= '0;
            aligned    <= 1'b0;
            byte_data  <= '0;
            byte_stb   <= 1'b0;
            sync_found <= 1'b0;
            chk_sum    <= '0;
        end else begin
            byte_stb   <= 1'b0;
            sync_found <= 1'b0;
            if (evt.err) begin
                aligned <= 1'b0;
                bcnt    <= '0;
                sr      <= '0;
            end else if (evt.vld) begin
                sr <= sr_n;
                if (framing) begin
                    bcnt <= bcnt + 1'b1;
                    if (bcnt == 3'd7) begin
                        byte_stb  <= 1'b1;
                        byte_data <= sr_n;
                        chk_sum   <= chk_sum + sr_n;
                    end
                end else if (sr_n == sync_byte) begin
                    aligned    <= 1'b1;
                    sync_found <= 1'b1;
                    bcnt       <= '0;
                    chk_sum    <= '0;
                end
            end
        end
    end

    AST_STB_AFTER_BIT: assert property (@(posedge clk) disable iff (rst)
        byte_stb |-> $past(evt.vld)); // R6
    AST_SUM_STEP: assert property (@(posedge clk) disable iff (rst)
        byte_stb |-> chk_sum == 8'($past(chk_sum) + byte_data)); // R9
    AST_ERR_UNLOCK: assert property (@(posedge clk) disable iff (rst)
        evt.err |=> !aligned); // R7
    AST_SYNC_LOCK: assert property (@(posedge clk) disable iff (rst)
        sync_found |-> aligned); // R5

endmodule

// File: rtl/cas_demod.sv
module cas_demod
    import cas_demod_pkg::*;
#(
    parameter int P0_CYC   = 64,
    parameter int P1_CYC   = 32,
    parameter int MIN_HIGH = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cas_in,
    input  logic       sync_en,
    input  logic [7:0] sync_byte,
    output logic [7:0] byte_data,
    output logic       byte_stb,
    output logic       sync_found,
    output logic       bit_err,
    output logic       aligned,
    output logic [7:0] chk_sum
);
    logic     rise_ok;
    bit_evt_t evt;

    cas_edge_filter #(.MIN_HIGH(MIN_HIGH)) u_filt (
        .clk(clk), .rst(rst), .din(cas_in), .rise_ok(rise_ok)
    );

    cas_period_meter #(.P0_CYC(P0_CYC), .P1_CYC(P1_CYC)) u_meter (
        .clk(clk), .rst(rst), .rise_ok(rise_ok), .evt(evt)
    );

    cas_byte_framer u_frame (
        .clk(clk), .rst(rst), .evt(evt), .sync_en(sync_en),
        .sync_byte(sync_byte), .byte_data(byte_data), .byte_stb(byte_stb),
        .sync_found(sync_found), .aligned(aligned), .chk_sum(chk_sum)
    );

    assign bit_err = evt.err;

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> !byte_stb && !sync_found && !bit_err && !aligned); // R1

endmodule

// File: tb/cas_demod_test.sv
`timescale 1ns/1ps
module cas_demod_test;
    localparam int P0 = 64;
    localparam int P1 = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cas_in = 1'b0;
    logic sync_en = 1'b1;
    logic [7:0] sync_byte = 8'h3C;
    logic [7:0] byte_data, chk_sum;
    logic byte_stb, sync_found, bit_err, aligned;

    int checks = 0, failures = 0;
    logic [7:0] got [0:15];
    int n_bytes = 0, n_sync = 0, n_err = 0;

    always #2.5 clk = ~clk;

    cas_demod #(.P0_CYC(P0), .P1_CYC(P1), .MIN_HIGH(3)) uut (
        .clk(clk), .rst(rst), .cas_in(cas_in), .sync_en(sync_en),
        .sync_byte(sync_byte), .byte_data(byte_data), .byte_stb(byte_stb),
        .sync_found(sync_found), .bit_err(bit_err), .aligned(aligned),
        .chk_sum(chk_sum)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (byte_stb && n_bytes < 16) begin
                got[n_bytes] = byte_data;
                n_bytes = n_bytes + 1;
            end
            if (sync_found) n_sync = n_sync + 1;
            if (bit_err) n_err = n_err + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset(input bit hunt);
        @(negedge clk);
        rst = 1'b1; cas_in = 1'b0; sync_en = hunt;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        n_bytes = 0; n_sync = 0; n_err = 0;
    endtask

    task automatic cyc(input int per);
        cas_in = 1'b1;
        repeat (per / 2) @(negedge clk);
        cas_in = 1'b0;
        repeat (per - per / 2) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 0; i < 8; i++) cyc(b[i] ? P1 : P0);
    endtask

    task automatic leader_sync();
        for (int i = 0; i < 8; i++) cyc(i % 2 == 0 ? P1 : P0);
        send_byte(8'h3C);
    endtask

    task automatic finish_rise();
        cyc(P1);
        repeat (20) @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset(1'b1);
        chk(!byte_stb && !sync_found && !bit_err && !aligned, "R1 flags", 0, 0);
        chk(chk_sum == 8'h00, "R1 chk_sum", chk_sum, 0);
    endtask

    task automatic t_hunt_bytes();
        do_reset(1'b1);
        for (int i = 0; i < 8; i++) cyc(i % 2 == 0 ? P1 : P0);
        repeat (20) @(negedge clk);
        chk(n_bytes == 0 && !aligned, "R5 no byte before sync", n_bytes, 0);
        send_byte(8'h3C);
        send_byte(8'hA5); send_byte(8'h00); send_byte(8'hFF); send_byte(8'h13);
        finish_rise();
        chk(n_sync == 1 && aligned, "R5 sync found", n_sync, 1);
        chk(n_bytes == 4, "R6 byte count", n_bytes, 4);
        chk(got[0] == 8'hA5 && got[1] == 8'h00, "R6 bytes 0/1", {got[0], got[1]}, 16'hA500);
        chk(got[2] == 8'hFF && got[3] == 8'h13, "R6 bytes 2/3", {got[2], got[3]}, 16'hFF13);
        chk(chk_sum == 8'hB7, "R9 checksum", chk_sum, 8'hB7);
        chk(n_err == 0, "R2 no error on nominal", n_err, 0);
    endtask

    task automatic t_gap_resync();
        do_reset(1'b1);
        leader_sync();
        send_byte(8'h11);
        cyc(P1);
        repeat (150) @(negedge clk);
        cyc(P1);
        repeat (20) @(negedge clk);
        chk(n_err == 1, "R3 long gap error", n_err, 1);
        chk(!aligned, "R7 lock dropped", aligned, 0);
        n_bytes = 0;
        send_byte(8'h77);
        finish_rise();
        chk(n_bytes == 0, "R7 no byte without sync", n_bytes, 0);
        send_byte(8'h3C); send_byte(8'h42);
        finish_rise();
        chk(n_bytes == 1 && got[0] == 8'h42, "R7 resync byte", got[0], 8'h42);
        chk(chk_sum == 8'h42, "R9 sum cleared at sync", chk_sum, 8'h42);
    endtask

    task automatic t_boundary();
        do_reset(1'b1);
        leader_sync();
        cyc(47); cyc(48); cyc(96); cyc(16); cyc(32); cyc(64); cyc(64); cyc(64);
        finish_rise();
        chk(n_err == 0, "R3 limits valid", n_err, 0);
        chk(n_bytes == 1 && got[0] == 8'h19, "R2 threshold byte", got[0], 8'h19);
    endtask

    task automatic t_short();
        do_reset(1'b1);
        leader_sync();
        cyc(15);
        finish_rise();
        chk(n_err == 1 && !aligned, "R3 short period error", n_err, 1);
        do_reset(1'b1);
        leader_sync();
        cyc(97);
        finish_rise();
        chk(n_err == 1 && !aligned, "R3 97 cycle error", n_err, 1);
    endtask

    task automatic t_glitch();
        do_reset(1'b1);
        leader_sync();
        for (int i = 0; i < 8; i++) begin
            if (i == 3) begin
                cas_in = 1'b1; repeat (32) @(negedge clk);
                cas_in = 1'b0; repeat (10) @(negedge clk);
                cas_in = 1'b1; repeat (2) @(negedge clk);
                cas_in = 1'b0; repeat (20) @(negedge clk);
            end else begin
                cyc((8'h81 >> i) & 1 ? P1 : P0);
            end
        end
        finish_rise();
        chk(n_err == 0, "R4 glitch no error", n_err, 0);
        chk(n_bytes == 1 && got[0] == 8'h81, "R4 glitch byte", got[0], 8'h81);
    endtask

    task automatic t_raw();
        do_reset(1'b0);
        send_byte(8'h5A); send_byte(8'hC3);
        finish_rise();
        chk(n_bytes == 2 && got[0] == 8'h5A && got[1] == 8'hC3, "R8 raw bytes",
            {got[0], got[1]}, 16'h5AC3);
        chk(!aligned && n_sync == 0, "R8 no lock in raw", aligned, 0);
        chk(chk_sum == 8'h1D, "R9 raw checksum", chk_sum, 8'h1D);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_hunt_bytes();
                t_gap_resync();
                t_boundary();
                t_short();
                t_glitch();
                t_raw();
            end
            begin
                repeat (150000) @(posedge clk);
                chk(1'b0, "watchdog", 0, 1);
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule